// File: doc/BRIEF.md
# Precision Time Counter with Fractional Rate Trim

This block keeps a precision-time-protocol time value in hardware: an unsigned 32-bit seconds count, a 30-bit nanoseconds count that always stays below one billion, and a 32-bit sub-nanosecond fraction in units of 2^-32 ns. A fixed local clock drives it. The time advances once every `TICK_DIV` cycles of that clock, by `NOMINAL_NS` nanoseconds per advance (8 ns every two cycles of a 250 MHz clock by default). A signed rate trim builds up in the fraction. Each time the fraction overflows or underflows, the ns increment for that advance grows or shrinks by one, so the counter can run slightly fast or slow while its update period stays fixed.

Host software controls the counter through single-cycle request pulses. A load sets an absolute time. A step adds a signed nanosecond offset once. A rate write replaces the trim value. The counter never takes time from a remote master by itself. Software computes offsets and rate from the event timestamps and writes them back. Each capture channel records the current time on a rising edge of its input. It then holds that timestamp until software acknowledges it with a read pulse.

Top module: `ptp_tod_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are zero for the time, the fraction, every capture valid flag and every capture field; the rate trim becomes 0; any request not yet applied is dropped.
- R2: After reset is released, the time advances only at update edges. Update edges are every `TICK_DIV`-th rising edge, starting with the `TICK_DIV`-th (default 2). Between updates all time outputs hold. With no request and a zero trim, each update adds `NOMINAL_NS` (default 8) ns.
- R3: If an update takes the ns value to 1,000,000,000 or above, it subtracts 1,000,000,000 and adds one second. If it takes ns below zero, it adds 1,000,000,000 and subtracts one second. Seconds wrap modulo 2^32, so 0xFFFFFFFF moves to 0.
- R4: A load update sets seconds and ns to the loaded values (ns below 1e9) and clears the fraction. On that update the nominal advance and the trim carry are not applied.
- R5: The rate trim is a signed 32-bit two's complement value in units of 2^-32 ns. On each non-load update the trim is added to the unsigned 32-bit fraction, and the result modulo 2^32 is kept. A carry out adds 1 ns to that update's advance and a borrow subtracts 1 ns. The trim keeps its value until it is rewritten.
- R6: A step adds its signed 32-bit ns offset exactly once, on the update that applies it, on top of that update's normal advance. The offset magnitude is at most 999,999,990.
- R7: When load, step and rate requests meet in one update, the order is load, then step, then rate. On a load update the result is the loaded time plus the step, and the fraction is 0. On a non-load update the new trim is already used for that update's fraction sum.
- R8: A request is a one-cycle pulse in any cycle. It takes effect on the next update edge, including the edge in the same cycle. A later request of the same kind before that edge replaces the earlier values.
- R9: Channel i captures when `cap_in[i]` is high at an edge after being low at the previous edge and its valid flag is clear. The seconds and ns shown on the time outputs in that cycle appear in the channel's fields, with valid set, after the edge.
- R10: While valid is set, rising edges on that channel are ignored and the stored fields hold. A `cap_rd[i]` pulse while valid is set clears valid after the edge and keeps the fields. A rising edge in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local update clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Pulse: load absolute time |
| load_sec | input | 32 | Seconds value for a load |
| load_ns | input | 30 | Nanoseconds value for a load, below 1e9 |
| step_req | input | 1 | Pulse: apply a signed ns offset once |
| step_ns | input | 32 | Signed ns offset for a step |
| rate_wr | input | 1 | Pulse: replace the rate trim |
| rate_val | input | 32 | Signed rate trim, 2^-32 ns per update |
| cap_in | input | NUM_CAP | Capture event inputs, rising edge active |
| cap_rd | input | NUM_CAP | Capture acknowledge pulses |
| time_sec | output | 32 | Current seconds |
| time_ns | output | 30 | Current nanoseconds |
| time_frac | output | 32 | Current fraction, 2^-32 ns units |
| cap_valid | output | NUM_CAP | Capture holds an unread timestamp |
| cap_sec | output | NUM_CAP*32 | Captured seconds, channel i at [32i+31:32i] |
| cap_ns | output | NUM_CAP*30 | Captured ns, channel i at [30i+29:30i] |

## Verification
The assertions rely on the step offset never exceeding 999,999,990 ns in magnitude and on loaded ns values staying below one billion. Under those limits a single carry or borrow always brings ns back into range. The bench holds every generated offset and load value inside these bounds, including the random phase. Within them it reaches both extremes of the step range and values next to the ns and seconds wrap points. It also issues requests in update and non-update cycles, so pending requests are exercised along with immediate ones.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam int FRAC_W = 32;
  localparam int OFS_W  = 32;
  localparam int ACC_W  = NS_W + 4;
  localparam logic signed [ACC_W-1:0] NS_WRAP = ACC_W'(1000000000);

  typedef enum logic [1:0] {
    ADJ_NONE = 2'b00,
    ADJ_PLUS = 2'b01,
    ADJ_MINUS = 2'b11
  } adj_e;
endpackage

// File: rtl/ptp_tick_gen.sv
module ptp_tick_gen #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(TICK_DIV - 1));

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    end else begin : g_every
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ptp_frac_rate.sv
module ptp_frac_rate
  import ptp_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clear_frac,
  input  logic              rate_go,
  input  logic [FRAC_W-1:0] rate_new,
  output logic [FRAC_W-1:0] frac_q,
  output adj_e              adj
);
  localparam int SW = FRAC_W + 2;

  logic [FRAC_W-1:0] rate_q;
  logic [FRAC_W-1:0] rate_use;
  logic [SW-1:0]     sum;

  always_comb begin
    rate_use = rate_go ? rate_new : rate_q;
    sum = {2'b00, frac_q} + {{2{rate_use[FRAC_W-1]}}, rate_use};
    if (sum[SW-1])         adj = ADJ_MINUS;
    else if (sum[SW-2])    adj = ADJ_PLUS;
    else                   adj = ADJ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= '0;
      rate_q <= '0;
    end else if (tick) begin
      rate_q <= rate_use;
      frac_q <= clear_frac ? '0 : sum[FRAC_W-1:0];
    end
  end

  AST_FRAC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(frac_q)); // R2
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (tick && clear_frac) |=> (frac_q == '0)); // R4
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
  import ptp_tod_pkg::*;
#(
  parameter int NOMINAL_NS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_go,
  input  logic [SEC_W-1:0] load_sec,
  input  logic [NS_W-1:0]  load_ns,
  input  logic             step_go,
  input  logic [OFS_W-1:0] step_ns,
  input  adj_e             adj,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_q
);
  localparam logic signed [ACC_W-1:0] NOM_S = ACC_W'(NOMINAL_NS);

  logic signed [ACC_W-1:0] base_ns;
  logic signed [ACC_W-1:0] adv_ns;
  logic signed [ACC_W-1:0] ofs_ns;
  logic signed [ACC_W-1:0] total_ns;
  logic signed [ACC_W-1:0] wrap_ns;
  logic [SEC_W-1:0]        base_sec;
  logic [SEC_W-1:0]        sec_d;
  logic [NS_W-1:0]         ns_d;

  always_comb begin
    base_ns  = load_go ? $signed({4'b0000, load_ns}) : $signed({4'b0000, ns_q});
    base_sec = load_go ? load_sec : sec_q;
    adv_ns   = load_go ? '0 : NOM_S + $signed({{(ACC_W-2){adj[1]}}, adj});
    ofs_ns   = step_go ? $signed({{(ACC_W-OFS_W){step_ns[OFS_W-1]}}, step_ns}) : '0;
    total_ns = base_ns + adv_ns + ofs_ns;
    if (total_ns >= NS_WRAP) begin
      wrap_ns = total_ns - NS_WRAP;
      sec_d   = base_sec + 1'b1;
    end else if (total_ns < 0) begin
      wrap_ns = total_ns + NS_WRAP;
      sec_d   = base_sec - 1'b1;
    end else begin
      wrap_ns = total_ns;
      sec_d   = base_sec;
    end
    ns_d = wrap_ns[NS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (tick) begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(sec_q) && $stable(ns_q))); // R2
  AST_NS_BELOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    ns_q < NS_W'(1000000000)); // R3
  AST_NOMINAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_go && !step_go && adj == ADJ_NONE && ns_q < NS_W'(999000000))
      |=> (ns_q == $past(ns_q) + NS_W'(NOMINAL_NS)) && $stable(sec_q)); // R2
endmodule

// File: rtl/ptp_capture_unit.sv
module ptp_capture_unit
  import ptp_tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_in,
  input  logic             ack,
  input  logic [SEC_W-1:0] now_sec,
  input  logic [NS_W-1:0]  now_ns,
  output logic             valid_q,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_q
);
  logic ev_prev;
  logic rise;

  assign rise = ev_in & ~ev_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_prev <= 1'b0;
      valid_q <= 1'b0;
      sec_q   <= '0;
      ns_q    <= '0;
    end else begin
      ev_prev <= ev_in;
      if (valid_q) begin
        if (ack) valid_q <= 1'b0;
      end else if (rise) begin
        valid_q <= 1'b1;
        sec_q   <= now_sec;
        ns_q    <= now_ns;
      end
    end
  end

  AST_CAP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ack) |=> (valid_q && $stable(sec_q) && $stable(ns_q))); // R10
  AST_CAP_ACK: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ack) |=> !valid_q); // R10
  AST_CAP_TAKE: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && rise) |=> (valid_q && sec_q == $past(now_sec) && ns_q == $past(now_ns))); // R9
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int NUM_CAP    = 2,
  parameter int TICK_DIV   = 2,
  parameter int NOMINAL_NS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_req,
  input  logic [SEC_W-1:0]          load_sec,
  input  logic [NS_W-1:0]           load_ns,
  input  logic                      step_req,
  input  logic [OFS_W-1:0]          step_ns,
  input  logic                      rate_wr,
  input  logic [FRAC_W-1:0]         rate_val,
  input  logic [NUM_CAP-1:0]        cap_in,
  input  logic [NUM_CAP-1:0]        cap_rd,
  output logic [SEC_W-1:0]          time_sec,
  output logic [NS_W-1:0]           time_ns,
  output logic [FRAC_W-1:0]         time_frac,
  output logic [NUM_CAP-1:0]        cap_valid,
  output logic [NUM_CAP*SEC_W-1:0]  cap_sec,
  output logic [NUM_CAP*NS_W-1:0]   cap_ns
);
  logic tick;

  logic              ld_pend, st_pend, rt_pend;
  logic [SEC_W-1:0]  ld_sec_p;
  logic [NS_W-1:0]   ld_ns_p;
  logic [OFS_W-1:0]  st_ns_p;
  logic [FRAC_W-1:0] rt_val_p;

  logic              load_go, step_go, rate_go;
  logic [SEC_W-1:0]  ld_sec_use;
  logic [NS_W-1:0]   ld_ns_use;
  logic [OFS_W-1:0]  st_ns_use;
  logic [FRAC_W-1:0] rt_val_use;
  adj_e              adj;

  ptp_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  // A request made in an update cycle bypasses the holding registers.
  assign load_go    = load_req | ld_pend;
  assign step_go    = step_req | st_pend;
  assign rate_go    = rate_wr  | rt_pend;
  assign ld_sec_use = load_req ? load_sec : ld_sec_p;
  assign ld_ns_use  = load_req ? load_ns  : ld_ns_p;
  assign st_ns_use  = step_req ? step_ns  : st_ns_p;
  assign rt_val_use = rate_wr  ? rate_val : rt_val_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_pend  <= 1'b0;
      st_pend  <= 1'b0;
      rt_pend  <= 1'b0;
      ld_sec_p <= '0;
      ld_ns_p  <= '0;
      st_ns_p  <= '0;
      rt_val_p <= '0;
    end else if (tick) begin
      ld_pend <= 1'b0;
      st_pend <= 1'b0;
      rt_pend <= 1'b0;
    end else begin
      if (load_req) begin
        ld_pend  <= 1'b1;
        ld_sec_p <= load_sec;
        ld_ns_p  <= load_ns;
      end
      if (step_req) begin
        st_pend <= 1'b1;
        st_ns_p <= step_ns;
      end
      if (rate_wr) begin
        rt_pend  <= 1'b1;
        rt_val_p <= rate_val;
      end
    end
  end

  ptp_frac_rate frac_i (
    .clk(clk), .rst(rst), .tick(tick),
    .clear_frac(load_go), .rate_go(rate_go), .rate_new(rt_val_use),
    .frac_q(time_frac), .adj(adj)
  );

  ptp_time_core #(.NOMINAL_NS(NOMINAL_NS)) core_i (
    .clk(clk), .rst(rst), .tick(tick),
    .load_go(load_go), .load_sec(ld_sec_use), .load_ns(ld_ns_use),
    .step_go(step_go), .step_ns(st_ns_use), .adj(adj),
    .sec_q(time_sec), .ns_q(time_ns)
  );

  generate
    for (genvar gi = 0; gi < NUM_CAP; gi++) begin : g_cap
      ptp_capture_unit cap_i (
        .clk(clk), .rst(rst),
        .ev_in(cap_in[gi]), .ack(cap_rd[gi]),
        .now_sec(time_sec), .now_ns(time_ns),
        .valid_q(cap_valid[gi]),
        .sec_q(cap_sec[gi*SEC_W +: SEC_W]),
        .ns_q(cap_ns[gi*NS_W +: NS_W])
      );
    end
  endgenerate

  AST_PEND_DRAINED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !(ld_pend || st_pend || rt_pend)); // R8
  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
    (tick && load_go && !step_go) |=> (time_sec == $past(ld_sec_use) && time_ns == $past(ld_ns_use))); // R4
endmodule

// File: tb/ptp_tod_counter_tb_top.sv
module ptp_tod_counter_tb_top;
  localparam int NC = 2;
  localparam int TD = 2;
  localparam int NOM = 8;
  localparam longint BILLION = 64'd1000000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_req = 1'b0;
  logic [31:0] load_sec = '0;
  logic [29:0] load_ns = '0;
  logic step_req = 1'b0;
  logic [31:0] step_ns = '0;
  logic rate_wr = 1'b0;
  logic [31:0] rate_val = '0;
  logic [NC-1:0] cap_in = '0;
  logic [NC-1:0] cap_rd = '0;
  logic [31:0] time_sec;
  logic [29:0] time_ns;
  logic [31:0] time_frac;
  logic [NC-1:0] cap_valid;
  logic [NC*32-1:0] cap_sec;
  logic [NC*30-1:0] cap_ns;

  always #10 clk = ~clk;

  ptp_tod_counter #(.NUM_CAP(NC), .TICK_DIV(TD), .NOMINAL_NS(NOM)) dut_i (
    .clk(clk), .rst(rst),
    .load_req(load_req), .load_sec(load_sec), .load_ns(load_ns),
    .step_req(step_req), .step_ns(step_ns),
    .rate_wr(rate_wr), .rate_val(rate_val),
    .cap_in(cap_in), .cap_rd(cap_rd),
    .time_sec(time_sec), .time_ns(time_ns), .time_frac(time_frac),
    .cap_valid(cap_valid), .cap_sec(cap_sec), .cap_ns(cap_ns)
  );

  typedef struct {
    string            tag;
    logic [31:0]      sec;
    logic [29:0]      ns;
    logic [31:0]      frac;
    logic [NC-1:0]    val;
    logic [NC*32-1:0] cs;
    logic [NC*30-1:0] cn;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  // Reference state, derived from the requirements
  logic [31:0] m_sec, m_frac, m_rate;
  longint      m_ns;
  int          phase;
  bit          p_ld, p_st, p_rt;
  logic [31:0] p_lsec, p_sns, p_rv;
  logic [29:0] p_lns;
  logic [NC-1:0] c_val, c_prev;
  logic [NC*32-1:0] c_sec;
  logic [NC*30-1:0] c_ns;

  task automatic model();
    bit tick, ld, st, rt;
    logic [31:0] lsec, sns, rv, sec;
    logic [29:0] lns;
    longint ns, s;
    int adj;
    if (rst) begin
      m_sec = '0; m_ns = 0; m_frac = '0; m_rate = '0; phase = 0;
      p_ld = 0; p_st = 0; p_rt = 0;
      c_val = '0; c_prev = '0; c_sec = '0; c_ns = '0;
      return;
    end
    tick = (phase == TD - 1);
    phase = tick ? 0 : phase + 1;
    for (int i = 0; i < NC; i++) begin
      if (c_val[i]) begin
        if (cap_rd[i]) c_val[i] = 1'b0;
      end else if (cap_in[i] && !c_prev[i]) begin
        c_val[i] = 1'b1;
        c_sec[i*32 +: 32] = m_sec;
        c_ns[i*30 +: 30] = m_ns[29:0];
      end
      c_prev[i] = cap_in[i];
    end
    ld = load_req || p_ld; lsec = load_req ? load_sec : p_lsec; lns = load_req ? load_ns : p_lns;
    st = step_req || p_st; sns = step_req ? step_ns : p_sns;
    rt = rate_wr || p_rt;  rv = rate_wr ? rate_val : p_rv;
    if (tick) begin
      if (!rt) rv = m_rate;
      if (ld) begin
        ns = longint'(lns); sec = lsec; m_frac = '0;
      end else begin
        s = longint'({32'd0, m_frac}) + longint'($signed(rv));
        adj = (s < 0) ? -1 : ((s >= 64'sd4294967296) ? 1 : 0);
        m_frac = s[31:0];
        ns = m_ns + NOM + adj; sec = m_sec;
      end
      if (st) ns = ns + longint'($signed(sns));
      if (ns >= BILLION) begin ns = ns - BILLION; sec = sec + 1; end
      else if (ns < 0) begin ns = ns + BILLION; sec = sec - 1; end
      m_ns = ns; m_sec = sec; m_rate = rv;
      p_ld = 0; p_st = 0; p_rt = 0;
    end else begin
      if (load_req) begin p_ld = 1; p_lsec = load_sec; p_lns = load_ns; end
      if (step_req) begin p_st = 1; p_sns = step_ns; end
      if (rate_wr)  begin p_rt = 1; p_rv = rate_val; end
    end
  endtask

  task automatic cyc();
    exp_t e;
    @(posedge clk);
    model();
    e.tag = cur_tag; e.sec = m_sec; e.ns = m_ns[29:0]; e.frac = m_frac;
    e.val = c_val; e.cs = c_sec; e.cn = c_ns;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_load(input logic [31:0] s, input logic [29:0] n);
    load_req = 1'b1; load_sec = s; load_ns = n; cyc(); load_req = 1'b0;
  endtask

  task automatic do_step(input logic [31:0] o);
    step_req = 1'b1; step_ns = o; cyc(); step_req = 1'b0;
  endtask

  task automatic do_rate(input logic [31:0] r);
    rate_wr = 1'b1; rate_val = r; cyc(); rate_wr = 1'b0;
  endtask

  // Monitor: compares one expected item per clock
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (time_sec !== e.sec || time_ns !== e.ns || time_frac !== e.frac) begin
        n_bad++;
        $display("FAIL %s time got %h.%0d frac %h expected %h.%0d frac %h",
                 e.tag, time_sec, time_ns, time_frac, e.sec, e.ns, e.frac);
      end
      if (cap_valid !== e.val || cap_sec !== e.cs || cap_ns !== e.cn) begin
        n_bad++;
        $display("FAIL %s capture got v=%b %h %h expected v=%b %h %h",
                 e.tag, cap_valid, cap_sec, cap_ns, e.val, e.cs, e.cn);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, and a request during reset is dropped
    cur_tag = "R1";
    load_req = 1'b1; load_sec = 32'd77; load_ns = 30'd5;
    run(2);
    load_req = 1'b0;
    run(3);
    rst = 1'b0;
    // R2: nominal free running, update every second edge
    cur_tag = "R2";
    run(40);
    // R4 and R3: load near the ns wrap, then the seconds wrap
    cur_tag = "R4";
    do_load(32'd5, 30'd999999990);
    run(8);
    cur_tag = "R3";
    do_load(32'hFFFFFFFF, 30'd999999996);
    run(8);
    // R5: positive and negative trims, including extremes
    cur_tag = "R5";
    do_rate(32'h4000_0000); run(30);
    do_rate(32'hC000_0000); run(30);
    do_rate(32'h7FFF_FFFF); run(16);
    do_rate(32'h8000_0000); run(16);
    do_rate(32'h0000_0000); run(10);
    // R6: steps at both limits and a borrow from seconds
    cur_tag = "R6";
    do_step(32'd1000); run(5);
    do_load(32'd3, 30'd100); run(2);
    do_step(-32'sd500); run(5);
    do_step(32'd999999990); run(5);
    do_step(-32'sd999999990); run(5);
    // R7: load, step and rate together; step and rate together
    cur_tag = "R7";
    load_req = 1'b1; load_sec = 32'd10; load_ns = 30'd999999000;
    step_req = 1'b1; step_ns = 32'd2000;
    rate_wr = 1'b1; rate_val = 32'h8000_0000;
    cyc();
    load_req = 1'b0; step_req = 1'b0; rate_wr = 1'b0;
    run(10);
    step_req = 1'b1; step_ns = -32'sd300; rate_wr = 1'b1; rate_val = 32'hF000_0000;
    cyc();
    step_req = 1'b0; rate_wr = 1'b0;
    run(10);
    // R8: request in a non-update cycle replaced by a later one
    cur_tag = "R8";
    for (int k = 0; k < 4; k++) begin
      do_load(32'd100 + 32'(k), 30'd1000);
      do_load(32'd200 + 32'(k), 30'd2000);
      run(3);
      do_step(32'd50); run(k + 1);
    end
    // R9: capture on a rising edge
    cur_tag = "R9";
    cap_in[0] = 1'b1; run(3);
    cap_in[0] = 1'b0; run(2);
    // R10: further edges ignored while valid, then read clears
    cur_tag = "R10";
    cap_in[0] = 1'b1; run(2);
    cap_in[0] = 1'b0; run(2);
    cap_rd[0] = 1'b1; cyc(); cap_rd[0] = 1'b0;
    run(2);
    cur_tag = "R9";
    cap_in[1] = 1'b1; cyc(); cap_in[1] = 1'b0; run(3);
    cur_tag = "R10";
    cap_in[1] = 1'b1; cap_rd[1] = 1'b1; cyc();
    cap_in[1] = 1'b0; cap_rd[1] = 1'b0; run(3);
    cap_in[1] = 1'b1; cyc(); cap_in[1] = 1'b0; run(3);
    // Random mix of all requests and captures
    cur_tag = "R8";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      load_req = (r < 4);
      load_sec = $urandom();
      load_ns = 30'($urandom_range(0, 999999999));
      step_req = (r >= 4 && r < 12);
      step_ns = 32'($signed(int'($urandom_range(0, 1999999980)) - 999999990));
      rate_wr = (r >= 12 && r < 18);
      rate_val = $urandom();
      cap_in = NC'($urandom());
      cap_rd = NC'($urandom());
      cyc();
    end
    load_req = 1'b0; step_req = 1'b0; rate_wr = 1'b0; cap_in = '0; cap_rd = '0;
    run(4);
    // R1: reset again from a busy state
    cur_tag = "R1";
    rst = 1'b1; run(3);
    rst = 1'b0; cur_tag = "R2"; run(6);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule